// File: doc/BRIEF.md
# I2C Master Stop and Restart Sequencer

This block owns the bus-condition edges of a register-controlled I2C master. It produces the stop condition that ends a transfer, and it runs the bus-release phase that has to come before a repeated start. A start is only taken as a request. Once accepted, the block forms the start edge and then holds both lines low, which is the state a byte engine works from.

Software talks to the block through a four-bit control write: master, transmit, busy and pending. One code of these bits requests a stop. A different code frees the bus for a restart. In a restart, SDA is let go while SCL is still held low, and SCL is released after that, so the lines never show a stop. The bus stays marked busy until SCL is seen high.

The block drives two open-drain pull-down enables and samples the real line levels through synchronizers. It reports a busy flag and a last-received-bit flag that follows SCL. A start-ready flag rises only after the lines have been idle for a configurable number of clocks, which enforces the 4.7 µs start setup time.

Top module: `i2c_cond_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, both pull-down enables are 0, busy is 0 and start-ready is 0.
- R2: A start request is accepted only while start-ready is 1. An accepted start pulls SDA low with SCL released for HIGH_CYC cycles, then pulls SCL low as well, with busy at 1. A request made while start-ready is 0 is ignored.
- R3: In the held state, a control write with master=1, transmit=1, busy=0, pending=1 starts a stop. SCL stays pulled low for exactly LOW_CYC cycles from the cycle after the write. Any other code, for example all four bits at 1, starts no stop.
- R4: During a stop, SDA stays low until SCL has been sampled high for HIGH_CYC consecutive cycles. If another device stretches SCL low, the block waits.
- R5: After SDA is released, busy clears only when both lines are sampled high. Each stop gives exactly one SDA rise while SCL is high.
- R6: Control writes made while a stop is in progress have no effect on the lines or on busy.
- R7: In the held state, a control write with master=0, transmit=0, busy=0, pending=1 releases SDA while SCL is still held low for LOW_CYC cycles, and then releases SCL. No stop condition appears on the lines. Busy reads 1 until SCL is sampled high, and then reads 0.
- R8: The last-received-bit flag equals the SCL line level delayed by a two-flop synchronizer, so it follows a change after two clock edges.
- R9: Start-ready rises only after SETUP_CYC consecutive idle cycles with both lines sampled high. The default is 940 cycles, which is 4.7 µs at 200 MHz. A start is never issued with fewer idle cycles than that.
- R10: A held-state write that is neither the stop code nor the restart code loads the transmit bit as the direction. If the direction is receive (transmit=0) and nackSent is 0, the restart code is ignored. With nackSent at 1, the same write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWr | input | 1 | One-cycle strobe for a control write |
| ctlMaster | input | 1 | Control bit: master |
| ctlTransmit | input | 1 | Control bit: transmit direction |
| ctlBusy | input | 1 | Control bit: bus busy |
| ctlPending | input | 1 | Control bit: pending interrupt |
| startReq | input | 1 | Request to generate a start |
| nackSent | input | 1 | Byte engine has sent a high acknowledge bit as receiver |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| busBusy | output | 1 | Bus-busy status |
| lastRxBit | output | 1 | Synchronized SCL level (1: not held low) |
| startReady | output | 1 | Start setup time has elapsed on an idle bus |

## Verification
The assertions assume that the control inputs change only between clock edges and that the lines follow the wired-AND of this block's enables and those of other devices. They also assume that no other device pulls SDA low while this block is completing a stop. The bench builds each line as the AND of the block's release and a slave that may stretch only SCL. Every control write and start request is a one-cycle pulse driven on the falling edge. The bench stretches SCL only during the high phase of a stop, and nackSent is raised only around the restart write that needs it.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_HELD,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_RISE,
    ST_REL_SDA,
    ST_REL_SCL
  } condState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic sclDrive;
    logic sdaDrive;
  } dpCtl_t;

  typedef struct packed {
    logic master;
    logic transmit;
    logic busy;
    logic pending;
  } ctlWord_t;

  localparam ctlWord_t STOP_CODE    = '{master: 1'b1, transmit: 1'b1, busy: 1'b0, pending: 1'b1};
  localparam ctlWord_t RESTART_CODE = '{master: 1'b0, transmit: 1'b0, busy: 1'b0, pending: 1'b1};

endpackage

// File: rtl/i2c_sync_line.sv
module i2c_sync_line #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineSync
);
  logic [STAGES-1:0] chain;

  // lines are idle high, so the chain resets to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], lineIn};
  end

  assign lineSync = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_dp.sv
module i2c_cond_dp
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  dpCtl_t           ctl,
  output logic             sclS,
  output logic             sdaS,
  output logic [CNT_W-1:0] cnt,
  output logic             sclOe,
  output logic             sdaOe
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLines;
  logic [N_LINES-1:0] syncLines;

  assign rawLines = {sdaIn, sclIn};

  for (genvar i = 0; i < N_LINES; i++) begin : g_sync
    i2c_sync_line #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .lineIn  (rawLines[i]),
      .lineSync(syncLines[i])
    );
  end

  assign sclS = syncLines[0];
  assign sdaS = syncLines[1];

  // shared phase timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else if (ctl.cntInc) cnt <= cnt + 1'b1;
  end

  assign sclOe = ctl.sclDrive;
  assign sdaOe = ctl.sdaDrive;

  // R4
  sda_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.sdaDrive) |-> ($past(sclS) || $past(ctl.sclDrive)));

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
#(
  parameter int LOW_CYC   = 940,
  parameter int HIGH_CYC  = 800,
  parameter int SETUP_CYC = 940,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  ctlWord_t         wrWord,
  input  logic             startReq,
  input  logic             nackSent,
  input  logic             sclS,
  input  logic             sdaS,
  input  logic [CNT_W-1:0] cnt,
  output dpCtl_t           ctl,
  output logic             busBusy,
  output logic             startReady
);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_V   = CNT_W'(SETUP_CYC);

  condState_t st, nxt;
  logic txMode;
  logic isStop, isRestart, restartOk, inStop;

  assign isStop    = ctlWr && (wrWord == STOP_CODE);
  assign isRestart = ctlWr && (wrWord == RESTART_CODE);
  assign restartOk = txMode || nackSent;
  assign inStop    = (st == ST_STOP_LO) || (st == ST_STOP_HI) || (st == ST_STOP_RISE);

  always_comb begin
    nxt        = st;
    ctl.cntClr = 1'b0;
    ctl.cntInc = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (startReq && cnt == SETUP_V) begin
          nxt        = ST_START;
          ctl.cntClr = 1'b1;
        end else if (sclS && sdaS) begin
          ctl.cntInc = (cnt != SETUP_V);
        end else begin
          ctl.cntClr = 1'b1;
        end
      end
      ST_START: begin
        if (cnt == HIGH_LAST) begin
          nxt        = ST_HELD;
          ctl.cntClr = 1'b1;
        end else ctl.cntInc = 1'b1;
      end
      ST_HELD: begin
        if (isStop) begin
          nxt        = ST_STOP_LO;
          ctl.cntClr = 1'b1;
        end else if (isRestart && restartOk) begin
          nxt        = ST_REL_SDA;
          ctl.cntClr = 1'b1;
        end
      end
      ST_STOP_LO: begin
        if (cnt == LOW_LAST) begin
          nxt        = ST_STOP_HI;
          ctl.cntClr = 1'b1;
        end else ctl.cntInc = 1'b1;
      end
      ST_STOP_HI: begin
        if (!sclS) begin
          ctl.cntClr = 1'b1;
        end else if (cnt == HIGH_LAST) begin
          nxt        = ST_STOP_RISE;
          ctl.cntClr = 1'b1;
        end else ctl.cntInc = 1'b1;
      end
      ST_STOP_RISE: begin
        if (sclS && sdaS) begin
          nxt        = ST_IDLE;
          ctl.cntClr = 1'b1;
        end
      end
      ST_REL_SDA: begin
        if (cnt == LOW_LAST) begin
          nxt        = ST_REL_SCL;
          ctl.cntClr = 1'b1;
        end else ctl.cntInc = 1'b1;
      end
      ST_REL_SCL: begin
        if (sclS) begin
          nxt        = ST_IDLE;
          ctl.cntClr = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign ctl.sclDrive = (st == ST_HELD) || (st == ST_STOP_LO) || (st == ST_REL_SDA);
  assign ctl.sdaDrive = (st == ST_START) || (st == ST_HELD) ||
                        (st == ST_STOP_LO) || (st == ST_STOP_HI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      txMode <= 1'b1;
    end else begin
      st <= nxt;
      if (st == ST_IDLE && nxt == ST_START)
        txMode <= 1'b1;
      else if (st == ST_HELD && ctlWr && !isStop && !isRestart)
        txMode <= wrWord.transmit;
    end
  end

  assign busBusy    = (st != ST_IDLE);
  assign startReady = (st == ST_IDLE) && (cnt == SETUP_V);

  // R6
  stop_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    inStop |=> ((st == ST_STOP_LO) || (st == ST_STOP_HI) ||
                (st == ST_STOP_RISE) || (st == ST_IDLE)));

  // R9
  start_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_START && $past(st) == ST_IDLE) |-> ($past(cnt) == SETUP_V));

  // R5
  busy_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> $past(sclS));

  // R10
  rx_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_HELD && isRestart && !txMode && !nackSent) |=> (st == ST_HELD));

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int LOW_CYC     = 940,
  parameter int HIGH_CYC    = 800,
  parameter int SETUP_CYC   = 940,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctlWr,
  input  logic ctlMaster,
  input  logic ctlTransmit,
  input  logic ctlBusy,
  input  logic ctlPending,
  input  logic startReq,
  input  logic nackSent,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclOe,
  output logic sdaOe,
  output logic busBusy,
  output logic lastRxBit,
  output logic startReady
);
  import i2c_cond_pkg::*;

  localparam int MAX_A = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_C = (MAX_A > SETUP_CYC) ? MAX_A : SETUP_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  ctlWord_t         wrWord;
  dpCtl_t           ctl;
  logic             sclS, sdaS;
  logic [CNT_W-1:0] cnt;

  assign wrWord = '{master: ctlMaster, transmit: ctlTransmit, busy: ctlBusy, pending: ctlPending};

  i2c_cond_ctrl #(
    .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .SETUP_CYC(SETUP_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .wrWord(wrWord), .startReq(startReq),
    .nackSent(nackSent), .sclS(sclS), .sdaS(sdaS), .cnt(cnt), .ctl(ctl),
    .busBusy(busBusy), .startReady(startReady)
  );

  i2c_cond_dp #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .sclS(sclS), .sdaS(sdaS), .cnt(cnt), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  assign lastRxBit = sclS;

endmodule

// File: tb/i2c_cond_seq_test.sv
`timescale 1ns/1ps
module i2c_cond_seq_test;
  localparam int LOW_CYC = 940, HIGH_CYC = 800, SETUP_CYC = 940;
  localparam int S_IDLE = 0, S_START = 1, S_HELD = 2, S_SLO = 3, S_SHI = 4,
                 S_SRISE = 5, S_RSDA = 6, S_RSCL = 7;

  logic clk = 0, rstN = 0;
  logic ctlWr = 0, ctlMaster = 0, ctlTransmit = 0, ctlBusy = 0, ctlPending = 0;
  logic startReq = 0, nackSent = 0, holdScl = 0;
  logic sclOe, sdaOe, busBusy, lastRxBit, startReady;
  wire  sclLine = !(sclOe || holdScl);
  wire  sdaLine = !sdaOe;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_cond_seq uut (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlMaster(ctlMaster),
    .ctlTransmit(ctlTransmit), .ctlBusy(ctlBusy), .ctlPending(ctlPending),
    .startReq(startReq), .nackSent(nackSent), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .busBusy(busBusy), .lastRxBit(lastRxBit),
    .startReady(startReady)
  );

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkGe(string req, string what, int act, int minv);
    tests++;
    if (act < minv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected at least %0d", req, what, act, minv);
    end
  endtask

  // behavioural reference model
  int  mSt = S_IDLE, mCnt = 0, mTx = 1;
  bit  [1:0] mScl = 2'b11, mSda = 2'b11;
  bit  mSclOe, mSdaOe, mLineS, mLineD, mS, mD, mStop, mRel;
  int  mNx;

  function automatic bit expScl(int s);
    return (s == S_HELD) || (s == S_SLO) || (s == S_RSDA);
  endfunction
  function automatic bit expSda(int s);
    return (s == S_START) || (s == S_HELD) || (s == S_SLO) || (s == S_SHI);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = S_IDLE; mCnt = 0; mTx = 1; mScl = 2'b11; mSda = 2'b11;
    end else begin
      mLineS = !(expScl(mSt) || holdScl);
      mLineD = !expSda(mSt);
      mS = mScl[1]; mD = mSda[1];
      mStop = ctlWr && {ctlMaster, ctlTransmit, ctlBusy, ctlPending} == 4'b1101;
      mRel  = ctlWr && {ctlMaster, ctlTransmit, ctlBusy, ctlPending} == 4'b0001;
      mNx = mSt;
      case (mSt)
        S_IDLE:  if (startReq && mCnt == SETUP_CYC) begin mNx = S_START; mCnt = 0; end
                 else if (mS && mD) begin if (mCnt < SETUP_CYC) mCnt++; end
                 else mCnt = 0;
        S_START: if (mCnt == HIGH_CYC - 1) begin mNx = S_HELD; mCnt = 0; end else mCnt++;
        S_HELD:  if (mStop) begin mNx = S_SLO; mCnt = 0; end
                 else if (mRel && (mTx == 1 || nackSent)) begin mNx = S_RSDA; mCnt = 0; end
        S_SLO:   if (mCnt == LOW_CYC - 1) begin mNx = S_SHI; mCnt = 0; end else mCnt++;
        S_SHI:   if (!mS) mCnt = 0;
                 else if (mCnt == HIGH_CYC - 1) begin mNx = S_SRISE; mCnt = 0; end
                 else mCnt++;
        S_SRISE: if (mS && mD) begin mNx = S_IDLE; mCnt = 0; end
        S_RSDA:  if (mCnt == LOW_CYC - 1) begin mNx = S_RSCL; mCnt = 0; end else mCnt++;
        S_RSCL:  if (mS) begin mNx = S_IDLE; mCnt = 0; end
        default: mNx = S_IDLE;
      endcase
      if (mSt == S_IDLE && mNx == S_START) mTx = 1;
      else if (mSt == S_HELD && ctlWr && !mStop && !mRel) mTx = ctlTransmit;
      mSt = mNx;
      mScl = {mScl[0], mLineS};
      mSda = {mSda[0], mLineD};
      cyc++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2/R3/R7", "model sclOe", sclOe, expScl(mSt));
      check("R2/R4/R7", "model sdaOe", sdaOe, expSda(mSt));
      check("R5/R7", "model busBusy", busBusy, mSt != S_IDLE);
      check("R9", "model startReady", startReady, (mSt == S_IDLE) && (mCnt == SETUP_CYC));
      check("R8", "model lastRxBit", lastRxBit, mScl[1]);
    end
  end

  // line monitor: stop/start events, high run and idle run
  bit prevScl = 1, prevSda = 1;
  int highRun = 0, freeRun = 0, lastStopRun = 0, lastFreeRun = 0, stopCount = 0, startCount = 0;
  always @(posedge clk) begin
    if (rstN) begin
      if (prevScl && sclLine && !prevSda && sdaLine) begin
        stopCount++; lastStopRun = highRun;
      end
      if (prevScl && sclLine && prevSda && !sdaLine) begin
        startCount++; lastFreeRun = freeRun;
      end
      highRun = sclLine ? highRun + 1 : 0;
      freeRun = busBusy ? 0 : freeRun + 1;
      prevScl = sclLine; prevSda = sdaLine;
    end
  end

  task automatic pulseStart();
    @(negedge clk); startReq = 1;
    @(negedge clk); startReq = 0;
  endtask

  task automatic ctlWrite(bit m, bit t, bit b, bit p);
    @(negedge clk);
    {ctlMaster, ctlTransmit, ctlBusy, ctlPending} = {m, t, b, p};
    ctlWr = 1;
    @(negedge clk); ctlWr = 0;
  endtask

  // which: 0 busy low, 1 ready, 2 held
  task automatic waitFor(int which, string req);
    int n = 0;
    while (n < 20000 && !((which == 0 && !busBusy) || (which == 1 && startReady) ||
                          (which == 2 && sclOe && sdaOe && busBusy))) begin
      @(negedge clk); n++;
    end
    check(req, "wait completed", n < 20000, 1);
  endtask

  task automatic finishRun();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int n;
    int s0;
    repeat (4) @(negedge clk);
    check("R1", "sclOe in reset", sclOe, 0);
    check("R1", "busBusy in reset", busBusy, 0);
    rstN = 1;
    check("R1", "sclOe after reset", sclOe, 0);
    check("R1", "sdaOe after reset", sdaOe, 0);
    check("R1", "busBusy after reset", busBusy, 0);
    check("R1", "startReady after reset", startReady, 0);

    // R2: early start request ignored
    pulseStart();
    repeat (5) @(negedge clk);
    check("R2", "busy after early start", busBusy, 0);
    waitFor(1, "R9");
    checkGe("R9", "cycles to first ready", cyc, SETUP_CYC);

    pulseStart();
    waitFor(2, "R2");
    check("R2", "start edges seen", startCount, 1);
    checkGe("R9", "idle run before start", lastFreeRun, SETUP_CYC);

    // R3: all-ones write is not a stop
    ctlWrite(1, 1, 1, 1);
    repeat (3) @(negedge clk);
    check("R3", "sclOe after non-stop code", sclOe, 1);
    ctlWrite(1, 1, 0, 1);
    n = 0;
    while (sclOe && n < 5000) begin n++; @(negedge clk); end
    check("R3", "stop SCL low length", n, LOW_CYC);

    // R4/R6/R8: stretch during stop high phase
    holdScl = 1;
    repeat (3) @(negedge clk);
    check("R8", "lastRxBit while stretched", lastRxBit, 0);
    ctlWrite(0, 0, 0, 1);
    ctlWrite(1, 1, 1, 1);
    repeat (300) @(negedge clk);
    check("R6", "sclOe after writes in stop", sclOe, 0);
    check("R4", "sdaOe held during stretch", sdaOe, 1);
    check("R6", "busy after writes in stop", busBusy, 1);
    holdScl = 0;
    @(negedge clk);
    check("R8", "lastRxBit one edge after release", lastRxBit, 0);
    @(negedge clk);
    check("R8", "lastRxBit two edges after release", lastRxBit, 1);
    waitFor(0, "R5");
    check("R5", "stop count", stopCount, 1);
    checkGe("R4", "SCL high before SDA rise", lastStopRun, HIGH_CYC);

    // R7: restart release
    waitFor(1, "R9");
    pulseStart();
    waitFor(2, "R7");
    s0 = stopCount;
    ctlWrite(0, 0, 0, 1);
    check("R7", "SCL held in release", sclOe, 1);
    check("R7", "SDA released in release", sdaOe, 0);
    check("R7", "busy in release", busBusy, 1);
    waitFor(0, "R7");
    check("R7", "no stop during release", stopCount, s0);
    check("R7", "SCL freed", sclOe, 0);
    waitFor(1, "R9");
    pulseStart();
    waitFor(2, "R9");
    checkGe("R9", "idle run before repeated start", lastFreeRun, SETUP_CYC);

    // R10: receiver restart gating
    ctlWrite(1, 0, 1, 1);
    ctlWrite(0, 0, 0, 1);
    repeat (10) @(negedge clk);
    check("R10", "SCL held after refused restart", sclOe, 1);
    check("R10", "SDA held after refused restart", sdaOe, 1);
    nackSent = 1;
    ctlWrite(0, 0, 0, 1);
    nackSent = 0;
    check("R10", "SDA released after accepted restart", sdaOe, 0);
    check("R10", "SCL still held after accepted restart", sclOe, 1);
    waitFor(0, "R10");

    // final stop
    waitFor(1, "R9");
    pulseStart();
    waitFor(2, "R5");
    ctlWrite(1, 1, 0, 1);
    waitFor(0, "R5");
    check("R5", "second stop count", stopCount, 2);
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule